// File: doc/BRIEF.md
# 32-bit Five-Operation ALU with Status Flags

This block is a purely combinational arithmetic logic unit for a 32-bit datapath. It takes two operands and a 3-bit operation code and returns a 32-bit result together with three status flags: a zero indication, a two's complement overflow indication and the carry out of the top bit.

The operations are bitwise AND, bitwise OR, addition, subtraction and a signed less-than comparison.

Subtraction shares the adder with addition. Bit 2 of the operation code inverts the second operand and also supplies the carry into bit 0. The signed comparison is taken from the sign of the difference. When the difference overflows, that sign is flipped first.

The adder is a ripple chain of single-bit slices. A small decoder turns the operation code into a packed set of steering strobes for the datapath.

Top module: `flag_alu`

## Requirements
- R1: Opcode 3'b000 gives result = opA & opB, with overflowFlag = 0 and carryFlag = 0.
- R2: Opcode 3'b001 gives result = opA | opB, with overflowFlag = 0 and carryFlag = 0.
- R3: Opcode 3'b010 gives result = (opA + opB) mod 2^32. carryFlag is the carry out of bit 31 of that sum.
- R4: Opcode 3'b110 gives result = (opA - opB) mod 2^32, formed as opA + ~opB + 1. carryFlag is the carry out of bit 31 of that sum, so it is 1 exactly when opA >= opB taken as unsigned values.
- R5: For opcodes 3'b010 and 3'b110, overflowFlag is 1 exactly when the two values entering the adder (opA, and opB or ~opB) share a sign and the sum's sign differs from it. This is the same as the carry into bit 31 XOR the carry out of bit 31.
- R6: Opcode 3'b111 gives result = 1 when opA < opB as signed two's complement values, including the cases where opA - opB overflows. Otherwise it gives 0. Bits 31..1 are always 0, and overflowFlag = carryFlag = 0.
- R7: For every opcode, zeroFlag is 1 exactly when all 32 result bits are 0.
- R8: Opcodes 3'b011, 3'b100 and 3'b101 give result = 0, overflowFlag = 0, carryFlag = 0 and therefore zeroFlag = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 3 | Operation select |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | High when result is all zeros |
| overflowFlag | output | 1 | Signed overflow of add or subtract |
| carryFlag | output | 1 | Carry out of bit 31 of add or subtract |

## Verification
Operands are drawn from the corner values 0, 1, all ones, 0x7FFFFFFF and 0x80000000, crossed with every operation, and then from random pairs.

- The corner crossings separate a correct ripple carry from a broken one, because all ones plus one carries through every slice.
- Pairs that straddle the sign boundary separate carry-in/carry-out overflow from a plain sign test.
- Those same pairs show whether the comparison applies the overflow correction, since 0x80000000 against 1 flips the raw difference sign.
- Unused opcodes are applied with operands that would otherwise give nonzero results and set flags, so leakage from any datapath path shows at the ports.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int DATA_W = 32;
  localparam int OPC_W  = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_AND  = 3'b000,
    OPC_OR   = 3'b001,
    OPC_ADD  = 3'b010,
    OPC_SUB  = 3'b110,
    OPC_LESS = 3'b111
  } opcode_e;

  typedef enum logic [2:0] {
    SEL_AND  = 3'd0,
    SEL_OR   = 3'd1,
    SEL_SUM  = 3'd2,
    SEL_LESS = 3'd3,
    SEL_ZERO = 3'd4
  } result_sel_e;

  typedef struct packed {
    logic        invertB;
    logic        carryIn;
    logic        arithFlags;
    result_sel_e resultSel;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic aBit,
  input  logic bBit,
  input  logic invertB,
  input  logic carryIn,
  output logic andBit,
  output logic orBit,
  output logic sumBit,
  output logic carryOut
);
  logic bEff;

  always_comb begin
    bEff     = bBit ^ invertB;
    andBit   = aBit & bBit;
    orBit    = aBit | bBit;
    sumBit   = aBit ^ bEff ^ carryIn;
    carryOut = (aBit & bEff) | (aBit & carryIn) | (bEff & carryIn);
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import flag_alu_pkg::*;
#(
  parameter int OP_W = OPC_W
) (
  input  logic [OP_W-1:0] opCode,
  output alu_ctrl_t       ctrl
);
  localparam int TOP_BIT = OP_W - 1;

  always_comb begin
    ctrl.invertB    = opCode[TOP_BIT];
    ctrl.carryIn    = opCode[TOP_BIT];
    ctrl.resultSel  = SEL_ZERO;
    ctrl.arithFlags = 1'b0;
    case (opCode)
      OPC_AND:  ctrl.resultSel = SEL_AND;
      OPC_OR:   ctrl.resultSel = SEL_OR;
      OPC_ADD:  begin ctrl.resultSel = SEL_SUM;  ctrl.arithFlags = 1'b1; end
      OPC_SUB:  begin ctrl.resultSel = SEL_SUM;  ctrl.arithFlags = 1'b1; end
      OPC_LESS: ctrl.resultSel = SEL_LESS;
      default:  ctrl.resultSel = SEL_ZERO;
    endcase
  end

  // R4: subtraction and comparison must run the adder as A + ~B + 1
  always_comb begin
    if (opCode == OPC_SUB || opCode == OPC_LESS)
      assert_sub_setup_R4: assert (ctrl.invertB && ctrl.carryIn)
        else $error("subtract setup wrong");
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] resOut,
  output logic             zeroOut,
  output logic             ovfOut,
  output logic             carryOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] andVec, orVec, sumVec;
  logic             ovfRaw, lessBit;

  assign carry[0] = ctrl.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .aBit    (aIn[i]),
      .bBit    (bIn[i]),
      .invertB (ctrl.invertB),
      .carryIn (carry[i]),
      .andBit  (andVec[i]),
      .orBit   (orVec[i]),
      .sumBit  (sumVec[i]),
      .carryOut(carry[i+1])
    );
  end

  always_comb begin
    ovfRaw  = carry[WIDTH] ^ carry[MSB];
    lessBit = sumVec[MSB] ^ ovfRaw;
    case (ctrl.resultSel)
      SEL_AND:  resOut = andVec;
      SEL_OR:   resOut = orVec;
      SEL_SUM:  resOut = sumVec;
      SEL_LESS: resOut = {{(WIDTH-1){1'b0}}, lessBit};
      default:  resOut = '0;
    endcase
    zeroOut  = ~|resOut;
    ovfOut   = ctrl.arithFlags & ovfRaw;
    carryOut = ctrl.arithFlags & carry[WIDTH];
  end

  // R3 / R4: the ripple chain agrees with a word-level sum
  always_comb begin
    if (ctrl.resultSel == SEL_SUM && !ctrl.invertB)
      assert_add_R3: assert ({carryOut, resOut} == {1'b0, aIn} + {1'b0, bIn})
        else $error("add mismatch");
    if (ctrl.resultSel == SEL_SUM && ctrl.invertB)
      assert_sub_R4: assert (resOut == aIn - bIn && carryOut == (aIn >= bIn))
        else $error("sub mismatch");
  end

  // R6: the comparison matches a signed compare
  always_comb begin
    if (ctrl.resultSel == SEL_LESS)
      assert_less_R6: assert (resOut == {{(WIDTH-1){1'b0}}, ($signed(aIn) < $signed(bIn))})
        else $error("less-than mismatch");
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [2:0]  opCode,
  output logic [31:0] result,
  output logic        zeroFlag,
  output logic        overflowFlag,
  output logic        carryFlag
);
  alu_ctrl_t ctrl;

  alu_ctrl #(.OP_W(OPC_W)) u_ctrl (
    .opCode(opCode),
    .ctrl  (ctrl)
  );

  alu_datapath #(.WIDTH(DATA_W)) u_dp (
    .aIn     (opA),
    .bIn     (opB),
    .ctrl    (ctrl),
    .resOut  (result),
    .zeroOut (zeroFlag),
    .ovfOut  (overflowFlag),
    .carryOut(carryFlag)
  );

  // R5: the carry-based overflow agrees with the operand sign rule
  always_comb begin
    if (opCode == 3'b010)
      assert_add_overflow_R5: assert (overflowFlag ==
          ((opA[31] == opB[31]) && (result[31] != opA[31])))
        else $error("add overflow mismatch");
    if (opCode == 3'b110)
      assert_sub_overflow_R5: assert (overflowFlag ==
          ((opA[31] != opB[31]) && (result[31] != opA[31])))
        else $error("sub overflow mismatch");
  end

  // R8: unused opcodes are silent
  always_comb begin
    if (opCode == 3'b011 || opCode == 3'b100 || opCode == 3'b101)
      assert_unused_quiet_R8: assert (result == '0 && zeroFlag && !overflowFlag && !carryFlag)
        else $error("unused opcode leaked");
  end

  // R1 / R7: logic ops raise no arithmetic flags, and zero tracks the AND result
  always_comb begin
    if (opCode == 3'b000)
      assert_and_zero_R7: assert (zeroFlag == ((opA & opB) == '0) && !overflowFlag && !carryFlag)
        else $error("and flags wrong");
  end
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] opA, opB, result;
  logic [2:0]  opCode;
  logic        zeroFlag, overflowFlag, carryFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  flag_alu uut (
    .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .zeroFlag(zeroFlag),
    .overflowFlag(overflowFlag), .carryFlag(carryFlag)
  );

  logic [31:0] corners [5];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    @(negedge clk);
    opA = a; opB = b; opCode = op;
    #2;
  endtask

  // Expected outputs, computed from the requirements alone
  task automatic expect_out(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                            output logic [31:0] r, output logic z, output logic v, output logic c);
    logic [32:0] wide;
    r = '0; v = 1'b0; c = 1'b0;
    case (op)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[31:0]; c = wide[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      3'b110: begin
        wide = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = wide[31:0]; c = wide[32];
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      3'b111: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
    z = (r == 32'd0);
  endtask

  task automatic check_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [2:0] op);
    logic [31:0] er;
    logic ez, ev, ec;
    apply(a, b, op);
    expect_out(a, b, op, er, ez, ev, ec);
    checks++;
    if (result !== er || zeroFlag !== ez || overflowFlag !== ev || carryFlag !== ec) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h: actual r=%h z=%b v=%b c=%b expected r=%h z=%b v=%b c=%b",
               tag, op, a, b, result, zeroFlag, overflowFlag, carryFlag, er, ez, ev, ec);
    end
  endtask

  task automatic test_initial_state;
    // R7: all-zero inputs under AND give a zero result with Z set
    check_op("R7", 32'h0, 32'h0, 3'b000);
  endtask

  task automatic test_logic;
    check_op("R1", 32'hF0F0_A5A5, 32'h0FF0_FFFF, 3'b000);
    check_op("R1", 32'hAAAA_AAAA, 32'h5555_5555, 3'b000);
    check_op("R2", 32'hF000_0000, 32'h0000_000F, 3'b001);
    check_op("R2", 32'h0, 32'h0, 3'b001);
  endtask

  task automatic test_add;
    check_op("R3", 32'd3, 32'd2, 3'b010);
    check_op("R3", 32'hFFFF_FFFF, 32'd1, 3'b010);
    check_op("R3", 32'h8000_0000, 32'h8000_0000, 3'b010);
  endtask

  task automatic test_sub;
    check_op("R4", 32'd3, 32'd3, 3'b110);
    check_op("R4", 32'd2, 32'd3, 3'b110);
    check_op("R4", 32'd0, 32'd0, 3'b110);
  endtask

  task automatic test_overflow;
    check_op("R5", 32'h7FFF_FFFF, 32'd1, 3'b010);
    check_op("R5", 32'h8000_0000, 32'hFFFF_FFFF, 3'b010);
    check_op("R5", 32'h8000_0000, 32'd1, 3'b110);
    check_op("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
  endtask

  task automatic test_less;
    check_op("R6", 32'hFFFF_FFFA, 32'hFFFF_FFFB, 3'b111);
    check_op("R6", 32'd7, 32'd4, 3'b111);
    check_op("R6", 32'h8000_0000, 32'd1, 3'b111);
    check_op("R6", 32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
    check_op("R6", 32'd5, 32'd5, 3'b111);
  endtask

  task automatic test_unused;
    for (int k = 3; k <= 5; k++) begin
      check_op("R8", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 3'(k));
      check_op("R8", 32'h8000_0000, 32'h8000_0000, 3'(k));
    end
  endtask

  task automatic test_corners;
    logic [2:0] ops [5];
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int o = 0; o < 5; o++)
          check_op("R7", corners[i], corners[j], ops[o]);
  endtask

  task automatic test_random;
    logic [2:0] ops [5];
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
    for (int n = 0; n < 400; n++)
      check_op("R3", $urandom, $urandom, ops[n % 5]);
  endtask

  initial begin
    corners[0] = 32'h0;
    corners[1] = 32'h1;
    corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h8000_0000;
    opA = '0; opB = '0; opCode = 3'b000;
    test_initial_state();
    test_logic();
    test_add();
    test_sub();
    test_overflow();
    test_less();
    test_unused();
    test_corners();
    test_random();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule